// File: doc/BRIEF.md
# Way-Partitioned Reconfigurable Cache

This block is a write-back, set-associative cache shared by several requesters. Its ways are the unit of partitioning: a configuration port gives each way an enable bit and an owning requester. A request is looked up only in the enabled ways that its requester owns, and a miss allocates only into those ways. Requesters in different partitions therefore cannot evict or read each other's lines. A requester that owns several ways sees a set-associative cache. A requester that owns one way sees a direct-mapped cache. A requester that owns no ways is served uncached.

Each configuration write starts a scrub. The scrub walks every line of every way that is being disabled or is changing owner. It writes each valid line back to lower memory and invalidates it. Only then does the new configuration take effect. Requests are held off until the scrub ends. Misses are refilled through a one-word-per-line request/acknowledge interface to lower memory. If the chosen victim line is valid, it is written back first.

Top module: `way_part_cache`

## Requirements
- R1: A request address splits into byte offset `addr[1:0]`, set index `addr[3:2]` and tag `addr[15:4]` (default parameters). A request hits when an enabled way owned by the requester has its valid bit set and a stored tag equal to the address tag. The hit response comes the cycle after acceptance with `rsp_hit`=1. For a read, `rsp_rdata` is the stored word. For a write, the stored word is replaced and `rsp_rdata` returns the written word.
- R2: On a miss, the block first writes back the victim line if it is valid. It then reads the line from lower memory at the line-aligned address. It installs the line with its tag and sets the valid bit. It responds with `rsp_hit`=0, with the fetched word for a read or the written word for a write. A miss into an empty set makes exactly one memory read and no memory write.
- R3: Way `w` belongs to the requester whose ID sits in `cfg_owner[w*REQ_W +: REQ_W]`. Requesters never hit in, nor allocate into, ways they do not own. A write by one requester leaves another requester's copy of the same address unchanged.
- R4: A way whose bit in `cfg_enable` is 0 takes no part in lookup or allocation.
- R5: A configuration write marks a way as affected when that way is currently enabled and is either being disabled or changing owner. Every valid line in an affected way is written back to memory at its own address with its data, and is then invalidated. Lines in ways that are not affected keep their contents.
- R6: From the cycle `cfg_valid` is seen until `cfg_done` pulses for one cycle, `req_ready` stays low. The new enables and owners apply from that pulse onward.
- R7: The victim is chosen among the requester's owned ways. The lowest-numbered invalid one is taken first. If all are valid, the choice is round-robin, using a pointer kept per requester and per set. The pointer starts at 0 and moves to one past each way allocated, wrapping around.
- R8: A requester that owns no enabled way is served uncached. Each read is one memory read, and it returns the memory word with `rsp_hit`=0. Each write is one memory write. Nothing is installed.
- R9: After reset, all lines are invalid, every way is enabled and owned by requester 0, `req_ready` is high, and `rsp_valid`, `mem_req` and `cfg_done` are low.
- R10: With a single owned way, two addresses that share a set index evict each other, so alternating between them always misses.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_id | input | REQ_W | Requester identifier |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served from a cached line |
| rsp_rdata | output | DATA_W | Read word, or the written word for writes |
| cfg_valid | input | 1 | Configuration write, held until cfg_done |
| cfg_enable | input | NUM_WAYS | Per-way enable |
| cfg_owner | input | NUM_WAYS*REQ_W | Per-way owning requester |
| cfg_done | output | 1 | Scrub finished, configuration applied |
| mem_req | output | 1 | Lower-memory access request |
| mem_we | output | 1 | Lower-memory write |
| mem_addr | output | ADDR_W | Line-aligned lower-memory address |
| mem_wdata | output | DATA_W | Line written to lower memory |
| mem_ack | input | 1 | Lower-memory access complete |
| mem_rdata | input | DATA_W | Line read from lower memory, valid with mem_ack |

## Verification
The hardest case to reach is a scrub that finds valid lines in some ways that are being taken away while other ways hold lines that must survive. To set it up, the stimulus first fills one set completely through requester 0. It then forces two round-robin evictions, so the occupancy of every way in that set is known. Only then does it move two ways to requester 1, and it predicts exactly which write-backs the scrub issues and in what order. A later configuration disables one more way. This leaves requester 0 direct-mapped, and alternating conflicting addresses then exercise eviction in a single way while requester 1's modified copy of the same address stays untouched.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB,
      ST_FILL,
      ST_UNC,
      ST_SCRUB,
      ST_SWB
   } wpc_state_e;
endpackage

// File: rtl/wpc_way_match.sv
module wpc_way_match #(
   parameter int NUM_WAYS = 4,
   parameter int TAG_W    = 12
) (
   input  logic [NUM_WAYS-1:0]       owned,
   input  logic [NUM_WAYS-1:0]       valid,
   input  logic [NUM_WAYS*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]          tag,
   output logic [NUM_WAYS-1:0]       hit
);
   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign hit[w] = owned[w] & valid[w] & (tags[w*TAG_W +: TAG_W] == tag);
   end
endmodule

// File: rtl/wpc_victim_pick.sv
module wpc_victim_pick #(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] owned,
   input  logic [NUM_WAYS-1:0] valid,
   input  logic [WAY_W-1:0]    ptr,
   output logic [WAY_W-1:0]    victim
);
   logic             found;
   logic [WAY_W-1:0] cand;

   always_comb begin
      victim = ptr;
      found  = 1'b0;
      cand   = '0;
      for (int k = 0; k < NUM_WAYS; k++) begin
         if (!found && owned[k] && !valid[k]) begin
            victim = WAY_W'(k);
            found  = 1'b1;
         end
      end
      for (int k = 0; k < NUM_WAYS; k++) begin
         cand = ptr + WAY_W'(k);
         if (!found && owned[cand]) begin
            victim = cand;
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/way_part_cache.sv
module way_part_cache
   import wpc_pkg::*;
#(
   parameter int NUM_REQ  = 2,
   parameter int NUM_WAYS = 4,
   parameter int NUM_SETS = 4,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   localparam int REQ_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [REQ_W-1:0]          req_id,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_we,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      rsp_valid,
   output logic                      rsp_hit,
   output logic [DATA_W-1:0]         rsp_rdata,
   input  logic                      cfg_valid,
   input  logic [NUM_WAYS-1:0]       cfg_enable,
   input  logic [NUM_WAYS*REQ_W-1:0] cfg_owner,
   output logic                      cfg_done,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic                      mem_ack,
   input  logic [DATA_W-1:0]         mem_rdata
);
   localparam int WAY_W = $clog2(NUM_WAYS);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(NUM_SETS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
   localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(NUM_SETS - 1);

   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for index and offset");
   end

   // line storage
   logic                 vld      [NUM_WAYS][NUM_SETS];
   logic [TAG_W-1:0]     tag_mem  [NUM_WAYS][NUM_SETS];
   logic [DATA_W-1:0]    data_mem [NUM_WAYS][NUM_SETS];
   logic [WAY_W-1:0]     rr_ptr   [NUM_REQ][NUM_SETS];

   // partition state
   logic [NUM_WAYS-1:0]  way_en;
   logic [REQ_W-1:0]     way_owner [NUM_WAYS];

   wpc_state_e           state;
   logic [REQ_W-1:0]     l_id;
   logic [IDX_W-1:0]     l_idx;
   logic [TAG_W-1:0]     l_tag;
   logic                 l_we;
   logic [DATA_W-1:0]    l_wdata;
   logic [WAY_W-1:0]     l_way;

   logic [WAY_W-1:0]     s_way;
   logic [IDX_W-1:0]     s_set;
   logic [NUM_WAYS-1:0]  s_aff;
   logic [NUM_WAYS-1:0]  p_en;
   logic [REQ_W-1:0]     p_own [NUM_WAYS];
   logic                 s_last;

   // request decode
   logic [IDX_W-1:0]         a_idx;
   logic [TAG_W-1:0]         a_tag;
   logic [NUM_WAYS-1:0]      req_own;
   logic [NUM_WAYS-1:0]      col_vld;
   logic [NUM_WAYS*TAG_W-1:0] col_tags;
   logic [NUM_WAYS-1:0]      hit_mask;
   logic [WAY_W-1:0]         hit_way;
   logic [WAY_W-1:0]         vict;
   logic                     accept;
   logic                     scrub_active;
   logic                     unused_off;

   assign a_idx      = req_addr[OFF_W +: IDX_W];
   assign a_tag      = req_addr[ADDR_W-1 -: TAG_W];
   assign unused_off = ^req_addr[OFF_W-1:0];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_col
      assign req_own[w]                   = way_en[w] && (way_owner[w] == req_id);
      assign col_vld[w]                   = vld[w][a_idx];
      assign col_tags[w*TAG_W +: TAG_W]   = tag_mem[w][a_idx];
   end

   wpc_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
      .owned (req_own),
      .valid (col_vld),
      .tags  (col_tags),
      .tag   (a_tag),
      .hit   (hit_mask)
   );

   wpc_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .owned  (req_own),
      .valid  (col_vld),
      .ptr    (rr_ptr[req_id][a_idx]),
      .victim (vict)
   );

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (hit_mask[w]) hit_way = WAY_W'(w);
      end
   end

   assign req_ready    = (state == ST_IDLE) && !cfg_valid;
   assign accept       = req_valid && req_ready;
   assign scrub_active = (state == ST_SCRUB) || (state == ST_SWB);
   assign s_last       = (s_set == LAST_SET) && (s_way == LAST_WAY);

   // lower-memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {tag_mem[l_way][l_idx], l_idx, {OFF_W{1'b0}}};
            mem_wdata = data_mem[l_way][l_idx];
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {l_tag, l_idx, {OFF_W{1'b0}}};
         end
         ST_UNC: begin
            mem_req   = 1'b1;
            mem_we    = l_we;
            mem_addr  = {l_tag, l_idx, {OFF_W{1'b0}}};
            mem_wdata = l_wdata;
         end
         ST_SWB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {tag_mem[s_way][s_set], s_set, {OFF_W{1'b0}}};
            mem_wdata = data_mem[s_way][s_set];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_rdata <= '0;
         cfg_done  <= 1'b0;
         way_en    <= '1;
         l_id      <= '0;
         l_idx     <= '0;
         l_tag     <= '0;
         l_we      <= 1'b0;
         l_wdata   <= '0;
         l_way     <= '0;
         s_way     <= '0;
         s_set     <= '0;
         s_aff     <= '0;
         p_en      <= '1;
         for (int w = 0; w < NUM_WAYS; w++) begin
            way_owner[w] <= '0;
            p_own[w]     <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
               vld[w][s]      <= 1'b0;
               tag_mem[w][s]  <= '0;
               data_mem[w][s] <= '0;
            end
         end
         for (int r = 0; r < NUM_REQ; r++) begin
            for (int s = 0; s < NUM_SETS; s++) rr_ptr[r][s] <= '0;
         end
      end else begin
         rsp_valid <= 1'b0;
         cfg_done  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cfg_valid) begin
                  for (int w = 0; w < NUM_WAYS; w++) begin
                     p_own[w] <= cfg_owner[w*REQ_W +: REQ_W];
                     s_aff[w] <= way_en[w] &&
                                 (!cfg_enable[w] || (cfg_owner[w*REQ_W +: REQ_W] != way_owner[w]));
                  end
                  p_en  <= cfg_enable;
                  s_way <= '0;
                  s_set <= '0;
                  state <= ST_SCRUB;
               end else if (accept) begin
                  l_id    <= req_id;
                  l_idx   <= a_idx;
                  l_tag   <= a_tag;
                  l_we    <= req_we;
                  l_wdata <= req_wdata;
                  l_way   <= vict;
                  if (req_own == '0) begin
                     state <= ST_UNC;
                  end else if (|hit_mask) begin
                     rsp_valid <= 1'b1;
                     rsp_hit   <= 1'b1;
                     if (req_we) begin
                        data_mem[hit_way][a_idx] <= req_wdata;
                        rsp_rdata                <= req_wdata;
                     end else begin
                        rsp_rdata <= data_mem[hit_way][a_idx];
                     end
                  end else if (vld[vict][a_idx]) begin
                     state <= ST_WB;
                  end else begin
                     state <= ST_FILL;
                  end
               end
            end
            ST_WB: begin
               if (mem_ack) state <= ST_FILL;
            end
            ST_FILL: begin
               if (mem_ack) begin
                  vld[l_way][l_idx]      <= 1'b1;
                  tag_mem[l_way][l_idx]  <= l_tag;
                  data_mem[l_way][l_idx] <= l_we ? l_wdata : mem_rdata;
                  rr_ptr[l_id][l_idx]    <= l_way + WAY_W'(1);
                  rsp_valid              <= 1'b1;
                  rsp_hit                <= 1'b0;
                  rsp_rdata              <= l_we ? l_wdata : mem_rdata;
                  state                  <= ST_IDLE;
               end
            end
            ST_UNC: begin
               if (mem_ack) begin
                  rsp_valid <= 1'b1;
                  rsp_hit   <= 1'b0;
                  rsp_rdata <= l_we ? l_wdata : mem_rdata;
                  state     <= ST_IDLE;
               end
            end
            ST_SCRUB: begin
               if (s_aff[s_way] && vld[s_way][s_set]) begin
                  state <= ST_SWB;
               end else if (s_last) begin
                  way_en    <= p_en;
                  way_owner <= p_own;
                  cfg_done  <= 1'b1;
                  state     <= ST_IDLE;
               end else if (s_set == LAST_SET) begin
                  s_set <= '0;
                  s_way <= s_way + WAY_W'(1);
               end else begin
                  s_set <= s_set + IDX_W'(1);
               end
            end
            ST_SWB: begin
               if (mem_ack) begin
                  vld[s_way][s_set] <= 1'b0;
                  if (s_last) begin
                     way_en    <= p_en;
                     way_owner <= p_own;
                     cfg_done  <= 1'b1;
                     state     <= ST_IDLE;
                  end else begin
                     state <= ST_SCRUB;
                     if (s_set == LAST_SET) begin
                        s_set <= '0;
                        s_way <= s_way + WAY_W'(1);
                     end else begin
                        s_set <= s_set + IDX_W'(1);
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/way_part_cache_sva.sv
module way_part_cache_sva #(
   parameter int NUM_WAYS = 4,
   parameter int ADDR_W   = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic                rsp_valid,
   input logic                rsp_hit,
   input logic                cfg_done,
   input logic                mem_req,
   input logic                mem_we,
   input logic                mem_ack,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [NUM_WAYS-1:0] hit_mask,
   input logic                scrub_active
);
   // R1: no two owned ways may hold the same tag in one set
   p_hit_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_mask));

   // R1: a hit response follows an accepted request by one cycle
   p_hit_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

   // R5: a scrub only ever moves lines out to memory
   p_scrub_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scrub_active && mem_req) |-> mem_we);

   // R6: the cycle before completion never accepted traffic
   p_done_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> $past(!req_ready));

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> !cfg_done);

   // R11: memory request held stable until acknowledged
   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind way_part_cache way_part_cache_sva #(.NUM_WAYS(NUM_WAYS), .ADDR_W(ADDR_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .cfg_done     (cfg_done),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_ack      (mem_ack),
   .mem_addr     (mem_addr),
   .hit_mask     (hit_mask),
   .scrub_active (scrub_active)
);

// File: tb/way_part_cache_tb.sv
module way_part_cache_tb;
   localparam int WAYS = 4;
   localparam int RW   = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [RW-1:0]   req_id = '0;
   logic [15:0]     req_addr = '0;
   logic            req_we = 1'b0;
   logic [31:0]     req_wdata = '0;
   logic            rsp_valid, rsp_hit;
   logic [31:0]     rsp_rdata;
   logic            cfg_valid = 1'b0;
   logic [WAYS-1:0] cfg_enable = '1;
   logic [WAYS*RW-1:0] cfg_owner = '0;
   logic            cfg_done;
   logic            mem_req, mem_we;
   logic [15:0]     mem_addr;
   logic [31:0]     mem_wdata;
   logic            mem_ack = 1'b0;
   logic [31:0]     mem_rdata = '0;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   way_part_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
      .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
      .cfg_valid(cfg_valid), .cfg_enable(cfg_enable), .cfg_owner(cfg_owner),
      .cfg_done(cfg_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #2 clk = ~clk;

   function automatic logic [31:0] f(input logic [15:0] a);
      return 32'hC0DE0000 ^ {16'h0, a};
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // lower-memory model
   logic [31:0] mem_arr [int];
   logic [15:0] wb_addr_q [$];
   logic [31:0] wb_data_q [$];
   int mem_lat = 0;
   int mem_rd_cnt = 0;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         mem_lat = 0;
      end else if (mem_req) begin
         mem_lat++;
         if (mem_lat == 2) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               mem_arr[int'(mem_addr)] = mem_wdata;
               wb_addr_q.push_back(mem_addr);
               wb_data_q.push_back(mem_wdata);
            end else begin
               mem_rdata = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : f(mem_addr);
               mem_rd_cnt++;
            end
         end
      end
   end

   // scoreboard
   logic        exp_hit_q [$];
   logic [31:0] exp_data_q [$];
   string       exp_rq_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_hit_q.size() == 0) begin
            check(1'b0, "R1", "unexpected response", rsp_rdata, 32'h0);
         end else begin
            automatic logic        eh = exp_hit_q.pop_front();
            automatic logic [31:0] ed = exp_data_q.pop_front();
            automatic string       rq = exp_rq_q.pop_front();
            check(rsp_hit == eh, rq, "rsp_hit", {31'h0, rsp_hit}, {31'h0, eh});
            check(rsp_rdata == ed, rq, "rsp_rdata", rsp_rdata, ed);
         end
      end
   end

   task automatic send(input logic [RW-1:0] id, input logic [15:0] a, input logic we,
                       input logic [31:0] wd, input logic eh, input logic [31:0] ed,
                       input string rq);
      exp_hit_q.push_back(eh);
      exp_data_q.push_back(ed);
      exp_rq_q.push_back(rq);
      @(negedge clk);
      req_valid = 1'b1;
      req_id    = id;
      req_addr  = a;
      req_we    = we;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      do @(posedge clk); while (exp_hit_q.size() != 0);
      @(negedge clk);
   endtask

   task automatic expect_wb(input logic [15:0] a, input logic [31:0] d, input string rq);
      if (wb_addr_q.size() == 0) begin
         check(1'b0, rq, "missing memory write", 32'h0, {16'h0, a});
      end else begin
         automatic logic [15:0] ga = wb_addr_q.pop_front();
         automatic logic [31:0] gd = wb_data_q.pop_front();
         check(ga == a, rq, "write-back address", {16'h0, ga}, {16'h0, a});
         check(gd == d, rq, "write-back data", gd, d);
      end
   endtask

   task automatic expect_no_wb(input string rq);
      check(wb_addr_q.size() == 0, rq, "extra memory writes",
            wb_addr_q.size(), 32'h0);
   endtask

   task automatic do_cfg(input logic [WAYS-1:0] en, input logic [WAYS*RW-1:0] own,
                         input string rq);
      automatic bit rdy_seen = 1'b0;
      @(negedge clk);
      cfg_valid  = 1'b1;
      cfg_enable = en;
      cfg_owner  = own;
      forever begin
         @(negedge clk);
         if (cfg_done) break;
         if (req_ready) rdy_seen = 1'b1;
      end
      cfg_valid = 1'b0;
      check(!rdy_seen, rq, "req_ready high during scrub", {31'h0, rdy_seen}, 32'h0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_errors++;
         $display("FAIL watchdog (all requirements): cycle %0d expected below %0d", cyc, 50000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(req_ready == 1'b1, "R9", "req_ready", {31'h0, req_ready}, 32'h1);
      check(rsp_valid == 1'b0, "R9", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
      check(mem_req == 1'b0, "R9", "mem_req", {31'h0, mem_req}, 32'h0);
      check(cfg_done == 1'b0, "R9", "cfg_done", {31'h0, cfg_done}, 32'h0);

      // R2: cold miss, one read, no write
      send(1'b0, 16'h0010, 1'b0, 32'h0, 1'b0, f(16'h0010), "R2");
      check(mem_rd_cnt == 1, "R2", "memory reads", mem_rd_cnt, 32'h1);
      expect_no_wb("R2");
      // R1: read and write hits
      send(1'b0, 16'h0010, 1'b0, 32'h0, 1'b1, f(16'h0010), "R1");
      send(1'b0, 16'h0012, 1'b1, 32'h11112222, 1'b1, 32'h11112222, "R1");
      send(1'b0, 16'h0010, 1'b0, 32'h0, 1'b1, 32'h11112222, "R1");
      expect_no_wb("R1");

      // R8/R9: requester 1 owns nothing after reset, served uncached
      send(1'b1, 16'h0010, 1'b0, 32'h0, 1'b0, f(16'h0010), "R8");
      check(mem_rd_cnt == 2, "R8", "memory reads", mem_rd_cnt, 32'h2);
      send(1'b1, 16'h0200, 1'b1, 32'h55556666, 1'b0, 32'h55556666, "R8");
      expect_wb(16'h0200, 32'h55556666, "R8");
      send(1'b1, 16'h0200, 1'b0, 32'h0, 1'b0, 32'h55556666, "R8");

      // R7: fill set 1, then round-robin evictions
      send(1'b0, 16'h0014, 1'b0, 32'h0, 1'b0, f(16'h0014), "R7");
      send(1'b0, 16'h0024, 1'b0, 32'h0, 1'b0, f(16'h0024), "R7");
      send(1'b0, 16'h0034, 1'b0, 32'h0, 1'b0, f(16'h0034), "R7");
      send(1'b0, 16'h0044, 1'b0, 32'h0, 1'b0, f(16'h0044), "R7");
      expect_no_wb("R7");
      send(1'b0, 16'h0054, 1'b0, 32'h0, 1'b0, f(16'h0054), "R7");
      expect_wb(16'h0014, f(16'h0014), "R7");
      send(1'b0, 16'h0024, 1'b0, 32'h0, 1'b1, f(16'h0024), "R7");
      send(1'b0, 16'h0014, 1'b0, 32'h0, 1'b0, f(16'h0014), "R7");
      expect_wb(16'h0024, f(16'h0024), "R7");

      // R5/R6: move ways 2 and 3 to requester 1
      do_cfg(4'b1111, 4'b1100, "R6");
      expect_wb(16'h0034, f(16'h0034), "R5");
      expect_wb(16'h0044, f(16'h0044), "R5");
      expect_no_wb("R5");
      send(1'b0, 16'h0054, 1'b0, 32'h0, 1'b1, f(16'h0054), "R5");
      send(1'b0, 16'h0010, 1'b0, 32'h0, 1'b1, 32'h11112222, "R5");
      send(1'b0, 16'h0034, 1'b0, 32'h0, 1'b0, f(16'h0034), "R5");
      expect_wb(16'h0054, f(16'h0054), "R7");

      // R3: isolation between partitions
      send(1'b1, 16'h0034, 1'b0, 32'h0, 1'b0, f(16'h0034), "R3");
      expect_no_wb("R3");
      send(1'b1, 16'h0034, 1'b0, 32'h0, 1'b1, f(16'h0034), "R3");
      send(1'b1, 16'h0034, 1'b1, 32'h33334444, 1'b1, 32'h33334444, "R3");
      send(1'b0, 16'h0034, 1'b0, 32'h0, 1'b1, f(16'h0034), "R3");

      // R4/R10: disable way 1, requester 0 becomes direct-mapped
      do_cfg(4'b1101, 4'b1100, "R6");
      expect_wb(16'h0014, f(16'h0014), "R4");
      expect_no_wb("R4");
      send(1'b0, 16'h0014, 1'b0, 32'h0, 1'b0, f(16'h0014), "R4");
      expect_wb(16'h0034, f(16'h0034), "R10");
      send(1'b0, 16'h0034, 1'b0, 32'h0, 1'b0, f(16'h0034), "R10");
      expect_wb(16'h0014, f(16'h0014), "R10");
      send(1'b1, 16'h0034, 1'b0, 32'h0, 1'b1, 32'h33334444, "R3");
      expect_no_wb("R10");

      repeat (10) @(negedge clk);
      check(exp_hit_q.size() == 0, "R1", "responses outstanding", exp_hit_q.size(), 32'h0);
      finish_run();
   end
endmodule